// File: doc/BRIEF.md
# Static LCD Segment Driver for a 3½-Digit Reading

This block turns a latched 3½-digit reading into the waveforms for a directly driven, non-multiplexed liquid-crystal display. Its inputs are three BCD digits (units, tens, hundreds), a flag for a leading one, an overrange flag, a sign bit and a lamp-test input. Its outputs are one backplane square wave and one drive line per segment: seven each for units, tens and hundreds, one line for the leading "1" (segments b and c of the thousands position wired together), and one line for the minus sign.

The backplane comes from dividing the input clock by `BP_DIV`. A lit segment is driven in antiphase with the backplane and a dark segment in phase with it, so the average voltage across the glass is zero. The digit values are captured only on a one-cycle strobe. The display therefore holds steady while the next conversion runs. While lamp test is held, every segment line sits at a constant high level and the glass shows -1888.

Top module: `lcd_static_drv`

## Requirements
- R1: After reset the backplane is low. It first rises on the `BP_DIV/2`-th clock edge after reset is released, and after that it toggles every `BP_DIV/2` clocks, which gives a period of `BP_DIV` clocks.
- R2: With lamp test low, every segment line equals `bp_o` when its segment is off and equals `~bp_o` when it is on. Between strobes, each backplane toggle inverts every segment line.
- R3: Each digit decodes with bit 0 = a through bit 6 = g, giving the on-state patterns 0:0x3F, 1:0x06, 2:0x5B, 3:0x4F, 4:0x66, 5:0x6D, 6:0x7D, 7:0x07, 8:0x7F, 9:0x6F.
- R4: BCD codes 10 to 15 blank their digit, so all seven segments are off.
- R5: The leading-one line is on when the last strobe saw `lead_one_i` or `ovr_i` high, and off otherwise.
- R6: The minus line is on when the last strobe saw `neg_i` high, and off otherwise.
- R7: Digit, sign and flag inputs have no effect on the outputs except in a cycle where `latch_i` is high. The captured state shows one clock after the strobe edge.
- R8: While `test_i` is high, all 23 segment lines are held high whatever the backplane phase. When `test_i` is released, the latched pattern returns without another strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_i | input | 1 | One-cycle strobe that captures a new reading |
| units_i | input | 4 | BCD units digit |
| tens_i | input | 4 | BCD tens digit |
| hund_i | input | 4 | BCD hundreds digit |
| lead_one_i | input | 1 | Thousands digit is 1 |
| ovr_i | input | 1 | Overrange flag; forces the leading one on |
| neg_i | input | 1 | Reading is negative |
| test_i | input | 1 | Lamp test: all segments on, steady level |
| bp_o | output | 1 | Backplane square wave |
| seg_units_o | output | 7 | Units segments, bit 0 = a to bit 6 = g |
| seg_tens_o | output | 7 | Tens segments, bit 0 = a to bit 6 = g |
| seg_hund_o | output | 7 | Hundreds segments, bit 0 = a to bit 6 = g |
| seg_lead_o | output | 1 | Combined line for the leading "1" |
| seg_minus_o | output | 1 | Minus sign |

## Verification
The assertions check on every cycle that the backplane changes only on the divider's terminal count and that each such toggle inverts the segment lines while no strobe is present. They also check that the outputs hold still between strobes and toggles, that lamp test drives all lines high, and that a non-decimal code or a cleared flag leaves its segments in phase with the backplane. The bench scenarios cover the rest: the exact length of each backplane half period, the full font table compared against independently computed patterns, overrange lighting the leading one, inputs that change without a strobe being ignored, and the latched pattern coming back after lamp test.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int SEG_W  = 7;
  localparam int DIGITS = 3;
  localparam int BCD_W  = 4;

  typedef logic [SEG_W-1:0] seg_t;

  // on-state of the whole glass
  typedef struct packed {
    logic                  minus;
    logic                  lead;
    seg_t [DIGITS-1:0]     dig;
  } disp_t;

  localparam int DISP_W = $bits(disp_t);

  // bit0 = a ... bit6 = g
  function automatic seg_t font(input logic [BCD_W-1:0] code);
    case (code)
      4'd0:    font = 7'h3F;
      4'd1:    font = 7'h06;
      4'd2:    font = 7'h5B;
      4'd3:    font = 7'h4F;
      4'd4:    font = 7'h66;
      4'd5:    font = 7'h6D;
      4'd6:    font = 7'h7D;
      4'd7:    font = 7'h07;
      4'd8:    font = 7'h7F;
      4'd9:    font = 7'h6F;
      default: font = '0;
    endcase
  endfunction
endpackage

// File: rtl/seg7_decode.sv
module seg7_decode
  import lcd_drv_pkg::*;
(
  input  logic [BCD_W-1:0] bcd_i,
  output seg_t             seg_o
);
  always_comb seg_o = font(bcd_i);

  // R4: non-decimal codes blank the digit
  always_comb begin
    if (bcd_i > 4'd9) a_r4_blank: assert (seg_o == '0);
  end
endmodule

// File: rtl/bp_divider.sv
module bp_divider #(
  parameter int BP_DIV = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bp_o,
  output logic toggle_o
);
  localparam int HALF = BP_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign toggle_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_o  <= 1'b0;
    end else if (toggle_o) begin
      cnt_q <= '0;
      bp_o  <= ~bp_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !toggle_o |=> $stable(bp_o));
  a_r1_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |=> (bp_o != $past(bp_o)));
  a_r1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/disp_latch.sv
module disp_latch
  import lcd_drv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  latch_i,
  input  disp_t nxt_i,
  output disp_t cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_o <= '0;
    else if (latch_i) cur_o <= nxt_i;
  end

  a_r7_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(cur_o));
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int BP_DIV = 800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       latch_i,
  input  logic [3:0] units_i,
  input  logic [3:0] tens_i,
  input  logic [3:0] hund_i,
  input  logic       lead_one_i,
  input  logic       ovr_i,
  input  logic       neg_i,
  input  logic       test_i,
  output logic       bp_o,
  output logic [6:0] seg_units_o,
  output logic [6:0] seg_tens_o,
  output logic [6:0] seg_hund_o,
  output logic       seg_lead_o,
  output logic       seg_minus_o
);
  logic [BCD_W-1:0] bcd [DIGITS];
  disp_t nxt, cur, drv;
  logic  bp, tick;

  assign bcd[0] = units_i;
  assign bcd[1] = tens_i;
  assign bcd[2] = hund_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dec
    seg7_decode u_dec (.bcd_i(bcd[d]), .seg_o(nxt.dig[d]));
  end
  assign nxt.lead  = lead_one_i | ovr_i;
  assign nxt.minus = neg_i;

  disp_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .latch_i(latch_i),
    .nxt_i  (nxt),
    .cur_o  (cur)
  );

  bp_divider #(.BP_DIV(BP_DIV)) u_bp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bp_o    (bp),
    .toggle_o(tick)
  );

  // on segment = antiphase, lamp test = DC high
  always_comb begin
    if (test_i) drv = '1;
    else        drv = disp_t'(cur ^ {DISP_W{bp}});
  end

  assign bp_o        = bp;
  assign seg_units_o = drv.dig[0];
  assign seg_tens_o  = drv.dig[1];
  assign seg_hund_o  = drv.dig[2];
  assign seg_lead_o  = drv.lead;
  assign seg_minus_o = drv.minus;

  a_r2_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !latch_i && tick) |=>
      (test_i || (seg_units_o == ~$past(seg_units_o) && seg_minus_o == ~$past(seg_minus_o))));
  a_r7_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !latch_i && !tick) |=>
      (test_i || ($stable(seg_units_o) && $stable(seg_tens_o) && $stable(seg_hund_o)
                  && $stable(seg_lead_o) && $stable(seg_minus_o))));
  a_r4_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && units_i > 4'd9) |=> (test_i || seg_units_o == {SEG_W{bp_o}}));
  a_r5_lead_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !lead_one_i && !ovr_i) |=> (test_i || seg_lead_o == bp_o));
  a_r5_lead_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && ovr_i) |=> (test_i || seg_lead_o != bp_o));
  a_r6_minus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && neg_i) |=> (test_i || seg_minus_o != bp_o));
  a_r8_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |-> (&{seg_units_o, seg_tens_o, seg_hund_o, seg_lead_o, seg_minus_o}));
endmodule

// File: tb/lcd_static_drv_tb.sv
module lcd_static_drv_tb;
  localparam int BP_DIV = 800;
  localparam int HALF   = BP_DIV / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic latch_i = 1'b0;
  logic [3:0] units_i = '0, tens_i = '0, hund_i = '0;
  logic lead_one_i = 1'b0, ovr_i = 1'b0, neg_i = 1'b0, test_i = 1'b0;
  logic bp_o, seg_lead_o, seg_minus_o;
  logic [6:0] seg_units_o, seg_tens_o, seg_hund_o;

  int total = 0;
  int bad   = 0;
  logic [22:0] exp_q[$];
  string       req_q[$];
  logic [22:0] last_exp = '0;
  logic        pend = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lcd_static_drv #(.BP_DIV(BP_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .latch_i(latch_i),
    .units_i(units_i), .tens_i(tens_i), .hund_i(hund_i),
    .lead_one_i(lead_one_i), .ovr_i(ovr_i), .neg_i(neg_i), .test_i(test_i),
    .bp_o(bp_o), .seg_units_o(seg_units_o), .seg_tens_o(seg_tens_o),
    .seg_hund_o(seg_hund_o), .seg_lead_o(seg_lead_o), .seg_minus_o(seg_minus_o)
  );

  wire [22:0] raw    = {seg_minus_o, seg_lead_o, seg_hund_o, seg_tens_o, seg_units_o};
  wire [22:0] on_now = raw ^ {23{bp_o}};

  function automatic logic [6:0] glyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // monitor: compares one clock after the strobe edge
  always @(posedge clk) pend <= latch_i;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [22:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      last_exp = e;
      check(on_now == e, r, {9'd0, on_now}, {9'd0, e});
    end
  end

  // driver: applies a reading with a strobe and queues its expectation
  task automatic show(input logic [3:0] u, input logic [3:0] t, input logic [3:0] h,
                      input logic l1, input logic ov, input logic ng, input string req);
    @(negedge clk);
    units_i = u; tens_i = t; hund_i = h;
    lead_one_i = l1; ovr_i = ov; neg_i = ng;
    latch_i = 1'b1;
    exp_q.push_back({ng, l1 | ov, glyph(h), glyph(t), glyph(u)});
    req_q.push_back(req);
    @(negedge clk);
    latch_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_bp_change();
    logic b0;
    b0 = bp_o;
    while (bp_o == b0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [22:0] prev;
    repeat (3) @(negedge clk);
    check(bp_o == 1'b0, "R1 reset bp", {31'd0, bp_o}, 0);
    check(raw == '0, "R1 reset segs", {9'd0, raw}, 0);
    rst_ni = 1'b1;

    // R1: half period lengths
    n = 0;
    while (!bp_o) begin @(negedge clk); n++; end
    check(n == HALF, "R1 first low phase", n, HALF);
    n = 0;
    while (bp_o) begin @(negedge clk); n++; end
    check(n == HALF, "R1 high phase", n, HALF);

    // R3 font, R5 leading one, R6 sign
    for (int d = 0; d < 10; d++)
      show(4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10), d[0], 1'b0, d[1], "R3 R5 R6 decode");

    // R4 non-decimal codes
    show(4'd10, 4'd13, 4'd15, 1'b0, 1'b0, 1'b0, "R4 blank");
    show(4'd12, 4'd4, 4'd11, 1'b1, 1'b0, 1'b1, "R4 blank mixed");

    // R5 overrange alone
    show(4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, "R5 overrange");

    // R7 inputs ignored without strobe
    show(4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b1, "R7 base");
    @(negedge clk);
    units_i = 4'd8; tens_i = 4'd8; hund_i = 4'd8;
    lead_one_i = 1'b1; ovr_i = 1'b1; neg_i = 1'b0;
    repeat (20) @(negedge clk);
    check(on_now == last_exp, "R7 hold", {9'd0, on_now}, {9'd0, last_exp});
    wait_bp_change();
    @(negedge clk);
    check(on_now == last_exp, "R7 hold across toggle", {9'd0, on_now}, {9'd0, last_exp});

    // R2 antiphase / in-phase relation
    prev = raw;
    wait_bp_change();
    check(raw == ~prev, "R2 invert on toggle", {9'd0, raw}, {9'd0, ~prev});
    check((raw ^ {23{bp_o}}) == last_exp, "R2 phase", {9'd0, raw ^ {23{bp_o}}}, {9'd0, last_exp});

    // R8 lamp test
    @(negedge clk);
    test_i = 1'b1;
    #1;
    check(raw == '1, "R8 test all on", {9'd0, raw}, 32'h7FFFFF);
    wait_bp_change();
    @(negedge clk);
    check(raw == '1, "R8 steady across toggle", {9'd0, raw}, 32'h7FFFFF);
    test_i = 1'b0;
    @(negedge clk);
    check(on_now == last_exp, "R8 release restores", {9'd0, on_now}, {9'd0, last_exp});

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule